// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the byte a host sees when it reads a flash array while an internal program or erase routine is running. The status is carried inside the read data: bit 7 reports completion of the operation, bit 6 flips on every status read, bit 5 flags an overrun of the time limit, bit 4 says which phase overran, and bit 3 shows whether an erase has actually started. When no operation is active the block passes array data through unchanged. The host therefore polls one address until the returned value shows completion.

The command decoder sends single-cycle start pulses for program, chip erase and sector erase. For a program start it also supplies bit 7 of the byte being written. The algorithm engine reports completion with `op_done`. A sector erase first opens an acceptance window, and `window_expire` closes it. The block counts clock cycles in the program and erase phases and moves to a sticky failure state when a phase reaches its parameterised limit. Only `reset_cmd` leaves that state.

The controller has five states: `ST_READ` (idle, pass-through), `ST_PROG`, `ST_WINDOW`, `ST_ERASE` and `ST_FAIL`. Its transitions are:
- `ST_READ` moves to `ST_PROG` on `prog_start`, to `ST_ERASE` on `chip_erase_start`, or to `ST_WINDOW` on `sect_erase_start`, in that order of priority.
- `ST_WINDOW` moves to `ST_ERASE` on `window_expire`. It returns to `ST_READ` on `prog_start`, `chip_erase_start` or `reset_cmd`, and stays put on a further `sect_erase_start`.
- `ST_PROG` and `ST_ERASE` return to `ST_READ` on `op_done`. Otherwise they move to `ST_FAIL` after `PROG_CYCLES` or `ERASE_CYCLES` clock cycles in the state.
- `ST_FAIL` returns to `ST_READ` on `reset_cmd`.

Top module: `opstat_gen`

## Requirements
- R1: After reset `busy` is 0. Whenever the block is idle, a read returns `array_rdata` as sampled at the strobe edge.
- R2: During a program, bit 7 of a status read is the inverse of the latched `prog_bit7`. Once `op_done` arrives, `busy` drops and reads return array data.
- R3: During a sector erase window and during an erase, bit 7 of a status read is 0. After `op_done`, reads return array data.
- R4: Bit 6 of the status is 0 on the first read after an operation starts and inverts on every later status read, including reads in the window and in the failure state. It stops once the block is idle.
- R5: After a program has spent `PROG_CYCLES` clock cycles in progress without `op_done`, status reads show bit 5 = 1 and bit 4 = 0. A read sampled in the last of those cycles still shows bit 5 = 0.
- R6: After an erase has spent `ERASE_CYCLES` clock cycles in progress without `op_done`, status reads show bit 5 = 1, bit 4 = 1 and bit 3 = 1.
- R7: Bit 3 reads 0 in the sector erase window and 1 once the erase runs. Time spent in the window does not count toward the erase limit, and extra sector erase starts keep the window open.
- R8: The failure state ignores `op_done` and start pulses, keeps `busy` at 1, and keeps reporting status until `reset_cmd`.
- R9: Bits 2..0 of every status read are 0.
- R10: While a program or erase runs, start pulses have no effect on the reported status.
- R11: A program or chip erase start received in the sector erase window abandons the window and returns the block to idle without starting that operation.
- R12: An `op_done` in the same cycle as the limit expiry completes the operation, with no failure reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Pulse: program operation begins |
| prog_bit7 | input | 1 | Bit 7 of the byte being programmed, taken with `prog_start` |
| chip_erase_start | input | 1 | Pulse: whole-array erase begins |
| sect_erase_start | input | 1 | Pulse: sector erase command accepted |
| window_expire | input | 1 | Pulse: sector acceptance window has closed |
| op_done | input | 1 | Pulse: internal algorithm finished |
| reset_cmd | input | 1 | Pulse: reset command, clears the failure state |
| rd_strobe | input | 1 | Host read request |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read result, registered, valid when `rd_valid` |
| rd_valid | output | 1 | One cycle after `rd_strobe` |
| busy | output | 1 | An operation is active or has failed |

## Verification
The assertions assume that every control input is a single-cycle pulse driven by a well-behaved decoder, and that `array_rdata` is stable around each strobe. They also assume the host polls with back-to-back strobes, so that two status reads in a row belong to the same operation. The bench drives all inputs at falling edges as one-cycle pulses and never issues two starts at once. It places the timeout and completion pulses in exact cycles counted from the start pulse, so that the limit boundary is hit on both sides.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

    typedef enum logic [2:0] {
        ST_READ   = 3'd0,
        ST_PROG   = 3'd1,
        ST_WINDOW = 3'd2,
        ST_ERASE  = 3'd3,
        ST_FAIL   = 3'd4
    } opst_e;

    localparam int STAT_W = 8;

    typedef struct packed {
        logic busy;
        logic prog_phase;
        logic erase_phase;
        logic failed;
        logic timing_on;
        logic sel_erase;
    } phase_t;

endpackage

// File: rtl/opstat_fsm.sv
module opstat_fsm
    import opstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   prog_start,
    input  logic   prog_bit7,
    input  logic   chip_erase_start,
    input  logic   sect_erase_start,
    input  logic   window_expire,
    input  logic   op_done,
    input  logic   reset_cmd,
    input  logic   expired,
    output phase_t phase,
    output logic   bit7_q
);

    opst_e state_q;
    opst_e state_d;
    logic  fail_erase_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ: begin
                if (prog_start)            state_d = ST_PROG;
                else if (chip_erase_start) state_d = ST_ERASE;
                else if (sect_erase_start) state_d = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (prog_start || chip_erase_start || reset_cmd) state_d = ST_READ;
                else if (window_expire)                          state_d = ST_ERASE;
            end
            ST_PROG, ST_ERASE: begin
                if (op_done)      state_d = ST_READ;
                else if (expired) state_d = ST_FAIL;
            end
            ST_FAIL: begin
                if (reset_cmd) state_d = ST_READ;
            end
            default: state_d = ST_READ;
        endcase
    end

    // state register and per-operation latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_READ;
            fail_erase_q <= 1'b0;
            bit7_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_READ && prog_start)
                bit7_q <= prog_bit7;
            if (state_d == ST_FAIL && state_q != ST_FAIL)
                fail_erase_q <= (state_q == ST_ERASE);
        end
    end

    // output decode
    always_comb begin
        phase.busy        = (state_q != ST_READ);
        phase.prog_phase  = (state_q == ST_PROG) || (state_q == ST_FAIL && !fail_erase_q);
        phase.erase_phase = (state_q == ST_ERASE) || (state_q == ST_FAIL && fail_erase_q);
        phase.failed      = (state_q == ST_FAIL);
        phase.timing_on   = (state_q == ST_PROG) || (state_q == ST_ERASE);
        phase.sel_erase   = (state_q == ST_ERASE);
    end

endmodule

// File: rtl/opstat_timer.sv
module opstat_timer #(
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_erase,
    output logic expired
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last    = sel_erase ? ERASE_LAST : PROG_LAST;
    assign expired = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/opstat_fmt.sv
module opstat_fmt
    import opstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              bit7_q,
    input  logic              rd_strobe,
    input  logic [STAT_W-1:0] array_rdata,
    output logic [STAT_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              tog_q;
    logic [STAT_W-1:0] status;

    always_comb begin
        status    = '0;
        status[7] = phase.prog_phase ? ~bit7_q : 1'b0;
        status[6] = tog_q;
        status[5] = phase.failed;
        status[4] = phase.failed && phase.erase_phase;
        status[3] = phase.erase_phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q    <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_strobe;
            if (!phase.busy)
                tog_q <= 1'b0;
            else if (rd_strobe)
                tog_q <= ~tog_q;
            if (rd_strobe)
                rd_data <= phase.busy ? status : array_rdata;
        end
    end

endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
    import opstat_pkg::*;
#(
    parameter int PROG_CYCLES  = 40,
    parameter int ERASE_CYCLES = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_start,
    input  logic       prog_bit7,
    input  logic       chip_erase_start,
    input  logic       sect_erase_start,
    input  logic       window_expire,
    input  logic       op_done,
    input  logic       reset_cmd,
    input  logic       rd_strobe,
    input  logic [7:0] array_rdata,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       busy
);

    phase_t phase;
    logic   bit7_q;
    logic   expired;

    opstat_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .prog_start       (prog_start),
        .prog_bit7        (prog_bit7),
        .chip_erase_start (chip_erase_start),
        .sect_erase_start (sect_erase_start),
        .window_expire    (window_expire),
        .op_done          (op_done),
        .reset_cmd        (reset_cmd),
        .expired          (expired),
        .phase            (phase),
        .bit7_q           (bit7_q)
    );

    opstat_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (phase.timing_on),
        .sel_erase (phase.sel_erase),
        .expired   (expired)
    );

    opstat_fmt u_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .bit7_q      (bit7_q),
        .rd_strobe   (rd_strobe),
        .array_rdata (array_rdata),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    assign busy = phase.busy;

endmodule

// File: rtl/opstat_gen_chk.sv
module opstat_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reset_cmd,
    input logic [7:0] array_rdata,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       busy
);

    a_r1_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(busy)) |-> (rd_data == $past(array_rdata)));

    a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy)) |-> (rd_data[2:0] == 3'b000));

    a_r4_d6_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && $past(busy) && $past(busy, 2))
        |-> (rd_data[6] != $past(rd_data[6])));

    a_r6_erase_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(busy) && rd_data[4]) |-> (rd_data[5] && rd_data[3]));

    a_r8_fail_exit_by_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rd_valid) && $past(rd_data[5]) && $past(busy, 2))
        |-> $past(reset_cmd));

endmodule

bind opstat_gen opstat_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_cmd   (reset_cmd),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .busy        (busy)
);

// File: tb/tb_opstat_gen.sv
module tb_opstat_gen;

    localparam int PROG_CYCLES  = 40;
    localparam int ERASE_CYCLES = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_start = 1'b0;
    logic       prog_bit7 = 1'b0;
    logic       chip_erase_start = 1'b0;
    logic       sect_erase_start = 1'b0;
    logic       window_expire = 1'b0;
    logic       op_done = 1'b0;
    logic       reset_cmd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_rdata = 8'hA5;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       busy;

    int checks = 0;
    int errors = 0;
    logic exp_tog = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    opstat_gen #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_bit7(prog_bit7),
        .chip_erase_start(chip_erase_start), .sect_erase_start(sect_erase_start),
        .window_expire(window_expire), .op_done(op_done), .reset_cmd(reset_cmd),
        .rd_strobe(rd_strobe), .array_rdata(array_rdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy)
    );

    // monitor: compare every read result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual %02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    function automatic logic [7:0] stat(input logic d7, input logic d6,
                                        input logic d5, input logic d4, input logic d3);
        return {d7, d6, d5, d4, d3, 3'b000};
    endfunction

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic rd_array(input string tag);
        exp_q.push_back(array_rdata);
        tag_q.push_back(tag);
        pulse(rd_strobe);
    endtask

    task automatic rd_status(input logic d7, input logic d5, input logic d4,
                             input logic d3, input string tag);
        exp_q.push_back(stat(d7, exp_tog, d5, d4, d3));
        tag_q.push_back(tag);
        exp_tog = ~exp_tog;
        pulse(rd_strobe);
    endtask

    task automatic chk_busy(input logic exp, input string tag);
        checks++;
        if (busy !== exp) begin
            errors++;
            $display("FAIL %s busy: actual %0b expected %0b", tag, busy, exp);
        end
    endtask

    task automatic drain;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and pass-through
        chk_busy(1'b0, "R1 reset");
        rd_array("R1 idle read");
        array_rdata = 8'h3C;
        rd_array("R1 idle read new data");

        // R2 program with bit7=1, R4 toggling, R10 ignored start
        prog_bit7 = 1'b1;
        exp_tog = 1'b0;
        pulse(prog_start);
        chk_busy(1'b1, "R2 program busy");
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R2 program d7 inverted");
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R4 second read toggles");
        pulse(chip_erase_start);
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R10 erase start ignored in program");
        pulse(op_done);
        chk_busy(1'b0, "R2 done");
        array_rdata = 8'h7E;
        rd_array("R2 true data after done");
        rd_array("R4 toggle stopped");

        // R2 program with bit7=0
        prog_bit7 = 1'b0;
        exp_tog = 1'b0;
        pulse(prog_start);
        rd_status(1'b1, 1'b0, 1'b0, 1'b0, "R2 program bit7=0");
        rd_status(1'b1, 1'b0, 1'b0, 1'b0, "R4 toggle bit7=0");
        pulse(op_done);
        rd_array("R2 after second program");

        // R3 chip erase, R9 low bits
        exp_tog = 1'b0;
        pulse(chip_erase_start);
        rd_status(1'b0, 1'b0, 1'b0, 1'b1, "R3 erase d7 low R9");
        pulse(prog_start);
        rd_status(1'b0, 1'b0, 1'b0, 1'b1, "R10 program start ignored in erase");
        pulse(op_done);
        chk_busy(1'b0, "R3 erase done");
        array_rdata = 8'hFF;
        rd_array("R3 data after erase");

        // R7 sector window: d3 low, no timing in window, extra sectors accepted
        exp_tog = 1'b0;
        pulse(sect_erase_start);
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R7 window d3 low");
        repeat (ERASE_CYCLES + 20) @(negedge clk);
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R7 window not timed");
        pulse(sect_erase_start);
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R7 extra sector keeps window");
        pulse(window_expire);
        rd_status(1'b0, 1'b0, 1'b0, 1'b1, "R7 erase running d3 high");
        pulse(op_done);
        rd_array("R3 data after sector erase");

        // R11 window abandoned by program start
        exp_tog = 1'b0;
        pulse(sect_erase_start);
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R11 window open");
        pulse(prog_start);
        chk_busy(1'b0, "R11 back to idle");
        array_rdata = 8'h12;
        rd_array("R11 idle read after abort");

        // R5 program timeout at the exact boundary, R8 sticky failure
        prog_bit7 = 1'b1;
        exp_tog = 1'b0;
        pulse(prog_start);
        repeat (PROG_CYCLES - 1) @(negedge clk);
        rd_status(1'b0, 1'b0, 1'b0, 1'b0, "R5 last cycle no fail");
        rd_status(1'b0, 1'b1, 1'b0, 1'b0, "R5 program fail d5 d4");
        pulse(op_done);
        chk_busy(1'b1, "R8 done ignored in fail");
        rd_status(1'b0, 1'b1, 1'b0, 1'b0, "R8 fail holds after done");
        pulse(chip_erase_start);
        rd_status(1'b0, 1'b1, 1'b0, 1'b0, "R8 start ignored in fail");
        pulse(reset_cmd);
        chk_busy(1'b0, "R8 reset clears fail");
        rd_array("R8 idle after reset");

        // R6 erase timeout
        exp_tog = 1'b0;
        pulse(chip_erase_start);
        repeat (ERASE_CYCLES + 5) @(negedge clk);
        rd_status(1'b0, 1'b1, 1'b1, 1'b1, "R6 erase fail d5 d4 d3");
        rd_status(1'b0, 1'b1, 1'b1, 1'b1, "R4 toggle in fail");
        pulse(reset_cmd);
        rd_array("R6 idle after reset");

        // R12 done coincides with expiry
        exp_tog = 1'b0;
        pulse(prog_start);
        repeat (PROG_CYCLES - 1) @(negedge clk);
        pulse(op_done);
        chk_busy(1'b0, "R12 done wins over expiry");
        array_rdata = 8'h5A;
        rd_array("R12 no fail reported");

        drain();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule